// File: doc/BRIEF.md
# Local Page Translation and Protection Table

This block turns a virtual local address into a host physical bus address, one 4 kB page at a time. The virtual page number selects an entry in an on-chip table. Each entry holds a valid flag, a physical frame number and a protection tag. The 12-bit page offset passes through unchanged. Neighbouring virtual pages may point at frames anywhere in host memory, so a region that looks contiguous to the network side can be scattered across physical memory. A page that has no valid entry cannot be reached.

Two kinds of request share the lookup port. Programmed accesses from remote nodes are translated and checked for validity only. Requests from the local DMA engine must also carry a requester tag equal to the entry's tag. Every response reports a fault code.

Software loads entries through a write port. After reset, a small state machine first sweeps the whole table to invalid (state `ST_SCRUB`) and then moves to `ST_SERVE`. It makes only two transitions:
- the sweep finishing on the last index takes it to `ST_SERVE`;
- `ST_SERVE` stays where it is until the next reset.

Lookups are pipelined with a fixed two-cycle latency, and one request can be accepted per cycle.

Top module: `ptt_xlate`

## Requirements
- R1: From reset, `req_ready` is low and stays low for exactly 2^VPN_W clock edges after reset release (256 by default) while every entry is made invalid. Table writes presented in that period are dropped. `resp_valid` is low throughout.
- R2: On a successful translation, `resp_phys[11:0]` equals `req_addr[11:0]`.
- R3: A valid entry gives `resp_phys = {frame, offset}` with fault code 0 (ok), whatever frame number each page holds.
- R4: A lookup of an invalid entry gives fault code 1 (invalid), and `resp_phys` is all zeros.
- R5: For a DMA request (`req_dma` = 1), a tag that differs from the entry's tag gives fault code 2 (tag mismatch) with `resp_phys` zero. An equal tag gives code 0.
- R6: For a non-DMA request (`req_dma` = 0), the tag is ignored: fault code 2 never occurs.
- R7: An address with any bit set at or above bit PAGE_BITS+VPN_W (bit 20 by default) is out of range. It gives fault code 3 with `resp_phys` zero, even when the low page index names a valid entry.
- R8: Each accepted request (`req_valid` and `req_ready` high at a clock edge) produces exactly one `resp_valid` pulse, two edges later. Requests can be accepted on consecutive cycles, and responses come back in order.
- R9: A table write changes only the results of requests accepted at a later edge. A request accepted at the same edge as the write, or still in flight, returns the old entry.
- R10: Faults are ranked: out of range (3) before invalid (1) before tag mismatch (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block accepts lookups (high in serve state) |
| req_addr | input | ADDR_W | Virtual local address |
| req_dma | input | 1 | Request comes from the DMA engine |
| req_tag | input | TAG_W | Protection tag of the requester |
| wr_en | input | 1 | Table entry write strobe |
| wr_page | input | VPN_W | Entry index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_frame | input | PFN_W | Physical frame number to store |
| wr_tag | input | TAG_W | Protection tag to store |
| resp_valid | output | 1 | Response present (one cycle per request) |
| resp_phys | output | PFN_W+PAGE_BITS | Physical address, zero on a fault |
| resp_fault | output | 2 | 0 ok, 1 invalid, 2 tag mismatch, 3 out of range |

## Verification
The bench targets the read-before-write edge case. It issues a lookup and a write to the same entry at the same edge, and again with the write one cycle behind the lookup. A table that forwarded the written data would return the new frame too early.

It tries a host write during the sweep. A design that lets that write through leaves page 0 valid after reset.

It sends out-of-range and invalid addresses together with wrong DMA tags. A design with the fault ranking wrong would report a tag mismatch where a range or validity fault belongs. Back-to-back requests expose any off-by-one latency or a dropped response.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_TAG     = 2'd2,
        FLT_RANGE   = 2'd3
    } fault_e;

    typedef enum logic {
        ST_SCRUB = 1'b0,
        ST_SERVE = 1'b1
    } init_state_e;

endpackage

// File: rtl/ptt_table.sv
module ptt_table #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 29
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    // Read-first: a same-edge write is not visible to the read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/ptt_init_fsm.sv
module ptt_init_fsm
    import ptt_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             serve,
    output logic             scrub_we,
    output logic [IDX_W-1:0] scrub_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    init_state_e state, state_nxt;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SCRUB: state_nxt = (idx_q == LAST_IDX) ? ST_SERVE : ST_SCRUB;
            ST_SERVE: state_nxt = ST_SERVE;
            default:  state_nxt = ST_SCRUB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SCRUB;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state == ST_SCRUB) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        serve     = 1'b0;
        scrub_we  = 1'b0;
        scrub_idx = idx_q;
        unique case (state)
            ST_SCRUB: scrub_we = 1'b1;
            ST_SERVE: serve    = 1'b1;
            default:  scrub_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptt_fault_eval.sv
module ptt_fault_eval
    import ptt_pkg::*;
(
    input  logic   oor,
    input  logic   ent_valid,
    input  logic   dma,
    input  logic   tag_equal,
    output fault_e fault
);
    // Ranking: range, then validity, then tag (tag only for DMA).
    always_comb begin
        if (oor) begin
            fault = FLT_RANGE;
        end else if (!ent_valid) begin
            fault = FLT_INVALID;
        end else if (dma && !tag_equal) begin
            fault = FLT_TAG;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/ptt_xlate.sv
module ptt_xlate
    import ptt_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int VPN_W     = 8,
    parameter int PFN_W     = 20,
    parameter int TAG_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_dma,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic                       wr_en,
    input  logic [VPN_W-1:0]           wr_page,
    input  logic                       wr_valid,
    input  logic [PFN_W-1:0]           wr_frame,
    input  logic [TAG_W-1:0]           wr_tag,
    output logic                       resp_valid,
    output logic [PFN_W+PAGE_BITS-1:0] resp_phys,
    output logic [1:0]                 resp_fault
);
    localparam int WIN_W = PAGE_BITS + VPN_W;
    localparam int PA_W  = PFN_W + PAGE_BITS;
    localparam int ENT_W = 1 + TAG_W + PFN_W;

    logic             serve, scrub_we;
    logic [VPN_W-1:0] scrub_idx;
    logic             accept, oor;
    logic             tbl_we;
    logic [VPN_W-1:0] tbl_wr_idx;
    logic [ENT_W-1:0] tbl_wr_data, tbl_rd_data;

    ptt_init_fsm #(.IDX_W(VPN_W)) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .serve    (serve),
        .scrub_we (scrub_we),
        .scrub_idx(scrub_idx)
    );

    assign req_ready = serve;
    assign accept    = req_valid & serve;

    generate
        if (ADDR_W > WIN_W) begin : g_range
            assign oor = |req_addr[ADDR_W-1:WIN_W];
        end else begin : g_norange
            assign oor = 1'b0;
        end
    endgenerate

    // Sweep owns the write port until serving; host writes then drop.
    assign tbl_we      = scrub_we | (serve & wr_en);
    assign tbl_wr_idx  = scrub_we ? scrub_idx : wr_page;
    assign tbl_wr_data = scrub_we ? '0 : {wr_valid, wr_tag, wr_frame};

    ptt_table #(.IDX_W(VPN_W), .ENT_W(ENT_W)) u_table (
        .clk    (clk),
        .we     (tbl_we),
        .wr_idx (tbl_wr_idx),
        .wr_data(tbl_wr_data),
        .rd_en  (accept),
        .rd_idx (req_addr[WIN_W-1:PAGE_BITS]),
        .rd_data(tbl_rd_data)
    );

    // Stage 1: request attributes travel alongside the table read.
    logic                 s1_valid, s1_dma, s1_oor;
    logic [PAGE_BITS-1:0] s1_off;
    logic [TAG_W-1:0]     s1_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_dma   <= 1'b0;
            s1_oor   <= 1'b0;
            s1_off   <= '0;
            s1_tag   <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_dma <= req_dma;
                s1_oor <= oor;
                s1_off <= req_addr[PAGE_BITS-1:0];
                s1_tag <= req_tag;
            end
        end
    end

    logic             ent_valid;
    logic [TAG_W-1:0] ent_tag;
    logic [PFN_W-1:0] ent_frame;
    fault_e           flt;

    assign ent_valid = tbl_rd_data[ENT_W-1];
    assign ent_tag   = tbl_rd_data[PFN_W +: TAG_W];
    assign ent_frame = tbl_rd_data[PFN_W-1:0];

    ptt_fault_eval u_eval (
        .oor      (s1_oor),
        .ent_valid(ent_valid),
        .dma      (s1_dma),
        .tag_equal(ent_tag == s1_tag),
        .fault    (flt)
    );

    // Stage 2: registered response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_phys  <= '0;
            resp_fault <= 2'd0;
        end else begin
            resp_valid <= s1_valid;
            if (s1_valid) begin
                resp_fault <= flt;
                resp_phys  <= (flt == FLT_NONE) ? PA_W'({ent_frame, s1_off}) : '0;
            end
        end
    end
endmodule

// File: rtl/ptt_xlate_chk.sv
module ptt_xlate_chk #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int VPN_W     = 8,
    parameter int PFN_W     = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [ADDR_W-1:0]          req_addr,
    input logic                       req_dma,
    input logic                       resp_valid,
    input logic [PFN_W+PAGE_BITS-1:0] resp_phys,
    input logic [1:0]                 resp_fault
);
    localparam int WIN_W = PAGE_BITS + VPN_W;

    logic acc, hi_set;
    assign acc    = req_valid && req_ready;
    assign hi_set = (req_addr >> WIN_W) != '0;

    a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> req_ready);

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 resp_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(acc, 2));

    a_r4_fault_zero_phys: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> resp_phys == '0);

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 2'd0) |->
            resp_phys[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0], 2));

    a_r6_pio_no_tag_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(req_dma, 2)) |-> resp_fault != 2'd2);

    a_r7_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(hi_set, 2)) |-> resp_fault == 2'd3);
endmodule

bind ptt_xlate ptt_xlate_chk #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .VPN_W(VPN_W), .PFN_W(PFN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_dma   (req_dma),
    .resp_valid(resp_valid),
    .resp_phys (resp_phys),
    .resp_fault(resp_fault)
);

// File: tb/test_ptt_xlate.sv
module test_ptt_xlate;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 8;
    localparam int VPN_W  = 8;
    localparam int PFN_W  = 20;
    localparam int PA_W   = 32;
    localparam int DEPTH  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_dma = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic wr_en = 1'b0, wr_valid = 1'b0;
    logic [VPN_W-1:0] wr_page = '0;
    logic [PFN_W-1:0] wr_frame = '0;
    logic [TAG_W-1:0] wr_tag = '0;
    logic req_ready, resp_valid;
    logic [PA_W-1:0] resp_phys;
    logic [1:0] resp_fault;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ptt_xlate i_ptt_xlate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dma(req_dma), .req_tag(req_tag),
        .wr_en(wr_en), .wr_page(wr_page), .wr_valid(wr_valid),
        .wr_frame(wr_frame), .wr_tag(wr_tag),
        .resp_valid(resp_valid), .resp_phys(resp_phys), .resp_fault(resp_fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_entry(input int page, input bit v, input int frame, input int tag);
        @(negedge clk);
        wr_en = 1'b1; wr_page = VPN_W'(page); wr_valid = v;
        wr_frame = PFN_W'(frame); wr_tag = TAG_W'(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drive_req(input logic [31:0] a, input bit d, input int t);
        req_valid = 1'b1; req_addr = a; req_dma = d; req_tag = TAG_W'(t);
    endtask

    task automatic expect_resp(input string req, input int f, input logic [31:0] p);
        chk(resp_valid === 1'b1, req, 64'(resp_valid), 64'd1);
        chk(resp_fault === 2'(f), req, 64'(resp_fault), 64'(f));
        chk(resp_phys === p, req, 64'(resp_phys), 64'(p));
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input bit d,
                          input int t, input int f, input logic [31:0] p);
        @(negedge clk);
        drive_req(a, d, t);
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b0, {req, " R8 early"}, 64'(resp_valid), 64'd0);
        @(negedge clk);
        expect_resp(req, f, p);
    endtask

    task automatic t_reset();
        int n = 0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b0, "R1 ready in reset", 64'(req_ready), 64'd0);
        chk(resp_valid === 1'b0, "R1 resp in reset", 64'(resp_valid), 64'd0);
        rst_n = 1'b1;
        while (req_ready !== 1'b1 && n < 4 * DEPTH) begin
            @(negedge clk);
            n++;
            if (n == 3) begin
                wr_en = 1'b1; wr_page = '0; wr_valid = 1'b1;
                wr_frame = 20'h12345; wr_tag = '0;
            end else begin
                wr_en = 1'b0;
            end
            if (resp_valid !== 1'b0) chk(1'b0, "R1 resp during sweep", 64'(resp_valid), 64'd0);
        end
        wr_en = 1'b0;
        chk(n == DEPTH, "R1 sweep length", 64'(n), 64'(DEPTH));
    endtask

    task automatic t_translate();
        put_entry(1, 1'b1, 'hABCDE, 3);
        put_entry(2, 1'b1, 'h00011, 7);
        put_entry(3, 1'b0, 'h55555, 3);
        put_entry(255, 1'b1, 'hFFFFF, 0);
        lookup("R3 R2 page1", 32'h0000_1123, 1'b0, 0, 0, 32'hABCD_E123);
        lookup("R3 R2 page2 scattered", 32'h0000_2FFF, 1'b0, 0, 0, 32'h0001_1FFF);
        lookup("R3 top page", 32'h000F_F000, 1'b0, 9, 0, 32'hFFFF_F000);
    endtask

    task automatic t_invalid();
        lookup("R4 invalid page3", 32'h0000_3010, 1'b0, 0, 1, 32'h0);
        lookup("R1 dropped sweep write", 32'h0000_0004, 1'b0, 0, 1, 32'h0);
        lookup("R4 never written page", 32'h0000_7000, 1'b1, 0, 1, 32'h0);
    endtask

    task automatic t_tag();
        lookup("R5 dma tag match", 32'h0000_1040, 1'b1, 3, 0, 32'hABCD_E040);
        lookup("R5 dma tag mismatch", 32'h0000_1040, 1'b1, 4, 2, 32'h0);
        lookup("R6 pio tag ignored", 32'h0000_1040, 1'b0, 4, 0, 32'hABCD_E040);
    endtask

    task automatic t_range();
        lookup("R7 bit20 set valid low page", 32'h0010_1005, 1'b0, 0, 3, 32'h0);
        lookup("R7 top bit set", 32'h8000_2000, 1'b0, 0, 3, 32'h0);
    endtask

    task automatic t_priority();
        lookup("R10 invalid before tag", 32'h0000_3000, 1'b1, 99, 1, 32'h0);
        lookup("R10 range before tag", 32'h0020_1000, 1'b1, 99, 3, 32'h0);
        lookup("R10 range before invalid", 32'h0040_3000, 1'b0, 0, 3, 32'h0);
    endtask

    task automatic t_stream();
        @(negedge clk); drive_req(32'h0000_1001, 1'b0, 0);
        @(negedge clk); drive_req(32'h0000_3002, 1'b0, 0);
        @(negedge clk); drive_req(32'h0000_2003, 1'b1, 6);
        expect_resp("R8 stream first", 0, 32'hABCD_E001);
        @(negedge clk); req_valid = 1'b0;
        expect_resp("R8 stream second", 1, 32'h0);
        @(negedge clk);
        expect_resp("R8 stream third", 2, 32'h0);
        @(negedge clk);
        chk(resp_valid === 1'b0, "R8 single pulse", 64'(resp_valid), 64'd0);
    endtask

    task automatic t_coherence();
        // Write one cycle behind the lookup.
        @(negedge clk); drive_req(32'h0000_2100, 1'b0, 0);
        @(negedge clk); req_valid = 1'b0;
        wr_en = 1'b1; wr_page = 8'd2; wr_valid = 1'b1; wr_frame = 20'h22222; wr_tag = 8'd7;
        @(negedge clk); wr_en = 1'b0;
        expect_resp("R9 in-flight keeps old", 0, 32'h0001_1100);
        lookup("R9 later sees new", 32'h0000_2100, 1'b0, 0, 0, 32'h2222_2100);
        // Write at the same edge as the lookup.
        @(negedge clk); drive_req(32'h0000_2200, 1'b0, 0);
        wr_en = 1'b1; wr_page = 8'd2; wr_valid = 1'b1; wr_frame = 20'h33333; wr_tag = 8'd7;
        @(negedge clk); req_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        expect_resp("R9 same edge keeps old", 0, 32'h2222_2200);
        lookup("R9 after same-edge write", 32'h0000_2200, 1'b0, 0, 0, 32'h3333_3200);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_translate();
        t_invalid();
        t_tag();
        t_range();
        t_priority();
        t_stream();
        t_coherence();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule